// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

The block contains a parameterised number of identical down-counting timers (two by default), each with a 16-bit counter. They sit behind a plain register bus: an address, a write strobe, write data and combinational read data. Software gives each timer a reload value and a control word, and can read the live count. The control word holds an enable bit, a two-bit mode and a four-bit prescale code. The mode picks one of three behaviours. A free-running timer wraps past zero. A periodic timer reloads after zero. A one-shot timer parks at zero. A shared status word gathers the per-timer interrupt flags, which are cleared by writing 1, and the per-timer restart strobes. Each timer drives its own interrupt line, which follows its flag.

The prescaler is non-linear. Code 0 lets the counter step on every clock. Code c from 1 to 15 makes it step once every 2^(c+1) clocks, so the divisors run from 4 up to 65536 and there is no divide-by-2. Everything runs on the bus clock.

Top module: `twin_tick_timer`

## Requirements
- R1: After reset every register reads 0, and every interrupt output is low.
- R2: Timer i (i = 0, 1) has three registers at byte offsets 0x10*(i+1) + {0x0, 0x4, 0x8}. These are the reload value (bits 15:0, read/write), the live count (bits 15:0, read only) and the control word. In the control word bit 7 is the enable, bits 5:4 are the mode and bits 3:0 are the prescale code; the other bits read 0. The status word is at offset 0x00.
- R3: With prescale code 0 an enabled counter steps on every clock. With code c ≥ 1 it steps once every 2^(c+1) clocks, and the first step comes 2^(c+1) clocks after the enable is written.
- R4: A disabled counter holds its value.
- R5: Mode 0 (free-running) steps from 0 to 0xFFFF.
- R6: Mode 1 (periodic) steps from 0 to the reload value.
- R7: Modes 2 and 3 (one-shot) hold the count at 0 once it has reached 0.
- R8: A step from 1 to 0 sets the timer's flag. Status bit i shows the flag, and interrupt output i equals it.
- R9: Writing 1 to status bit i clears flag i. Writing 0 there leaves the flag unchanged.
- R10: Writing 1 to status bit 4+i reloads counter i from its reload value and restarts its prescaler from zero. Status bit 4+i always reads 0.
- R11: A write to the reload value of a disabled timer also copies the value into its counter. A write to the reload value of an enabled timer does not change the counter.
- R12: Programming, running or restarting one timer does not change the other timer's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| irq | output | N_TIMERS (2) | Per-timer interrupt lines, equal to the flags |

## Verification
On every cycle the assertions check several step rules for each timer. A disabled counter does not move. A parked one-shot counter stays at zero. A free-running counter may only leave zero for 0xFFFF, and a periodic one only for its reload value. A restart loads the reload value, and an interrupt can rise only after a count of one. The exact prescale timing cannot be shown by a per-cycle rule, because the divisor range is too wide to unroll. The same holds for the readback of the register map, the effect of clearing flags, the loading of a disabled timer and the isolation between the two timers. The bench's scenarios show these by sampling the count at computed clock positions.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
   localparam int PSEL_W = 4;

   typedef enum logic [1:0] {
      MODE_FREE     = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_ONESHOT  = 2'd2,
      MODE_ONESHOT2 = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      logic              en;
      tmr_mode_e         mode;
      logic [PSEL_W-1:0] psel;
   } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PS_W  = 16,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam logic [PS_W-1:0] ONES = '1;
   localparam int MAX_SEL = (1 << SEL_W) - 1;

   generate
      if (PS_W < MAX_SEL + 1) begin : g_bad_width
         $error("tmr_prescaler: PS_W too small for the largest prescale code");
      end
   endgenerate

   logic [PS_W-1:0] div_q;
   logic [PS_W-1:0] msk;

   // code c >= 1 needs the low c+1 bits all ones: period 2^(c+1)
   always_comb msk = ONES >> (PS_W - 1 - int'(sel_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (clr_i)
         div_q <= '0;
      else if (run_i)
         div_q <= div_q + 1'b1;
   end

   assign tick_o = run_i && ((sel_i == '0) || ((div_q & msk) == msk));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import twin_timer_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PS_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_wr_i,
   input  logic [CNT_W-1:0] ld_data_i,
   input  logic             ctl_wr_i,
   input  tmr_ctl_t         ctl_data_i,
   input  logic             restart_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] load_o,
   output tmr_ctl_t         ctl_o,
   output logic             flag_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, load_q, cnt_nx;
   tmr_ctl_t         ctl_q;
   logic             flag_q, tick, hit;

   tmr_prescaler #(.PS_W(PS_W), .SEL_W(PSEL_W)) pre_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctl_q.en),
      .clr_i  (restart_i | ~ctl_q.en),
      .sel_i  (ctl_q.psel),
      .tick_o (tick)
   );

   always_comb begin
      if (cnt_q != '0)
         cnt_nx = cnt_q - ONE;
      else begin
         unique case (ctl_q.mode)
            MODE_FREE:     cnt_nx = '1;
            MODE_PERIODIC: cnt_nx = load_q;
            default:       cnt_nx = '0;
         endcase
      end
   end

   assign hit = tick && !restart_i && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
         ctl_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (ld_wr_i)  load_q <= ld_data_i;
         if (ctl_wr_i) ctl_q  <= ctl_data_i;
         if (restart_i)
            cnt_q <= load_q;
         else if (ld_wr_i && !ctl_q.en)
            cnt_q <= ld_data_i;
         else if (tick)
            cnt_q <= cnt_nx;
         flag_q <= hit | (flag_q & ~flag_clr_i);
      end
   end

   assign cnt_o  = cnt_q;
   assign load_o = load_q;
   assign ctl_o  = ctl_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/twin_tick_timer.sv
module twin_tick_timer
   import twin_timer_pkg::*;
#(
   parameter int N_TIMERS = 2,
   parameter int CNT_W    = 16,
   parameter int PS_W     = 16,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_TIMERS-1:0] irq
);
   localparam int SLOT_W  = ADDR_W - 4;
   localparam int RST_LSB = 4;

   generate
      if (N_TIMERS < 1 || N_TIMERS > 4) begin : g_bad_n
         $error("twin_tick_timer: N_TIMERS must be 1 to 4");
      end
      if ((1 << SLOT_W) <= N_TIMERS) begin : g_bad_addr
         $error("twin_tick_timer: ADDR_W too narrow for the timer slots");
      end
      if (CNT_W > DATA_W || DATA_W < 8) begin : g_bad_data
         $error("twin_tick_timer: DATA_W too narrow");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic [3:0]        regi;
   logic              stat_wr;
   assign slot    = bus_addr[ADDR_W-1:4];
   assign regi    = bus_addr[3:0];
   assign stat_wr = bus_we && (slot == '0) && (regi == 4'h0);

   logic [N_TIMERS-1:0]            ld_wr, ctl_wr, rst_req, flag_clr, flag, en;
   logic [N_TIMERS-1:0][CNT_W-1:0] cnt, load;
   logic [N_TIMERS-1:0][1:0]       mode;
   tmr_ctl_t                       ctl [N_TIMERS];
   tmr_ctl_t                       ctl_wdata;
   assign ctl_wdata = '{en: bus_wdata[7], mode: tmr_mode_e'(bus_wdata[5:4]),
                        psel: bus_wdata[PSEL_W-1:0]};

   generate
      for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
         logic sel;
         assign sel         = bus_we && (slot == SLOT_W'(i + 1));
         assign ld_wr[i]    = sel && (regi == 4'h0);
         assign ctl_wr[i]   = sel && (regi == 4'h8);
         assign rst_req[i]  = stat_wr && bus_wdata[RST_LSB + i];
         assign flag_clr[i] = stat_wr && bus_wdata[i];

         tmr_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_wr_i    (ld_wr[i]),
            .ld_data_i  (bus_wdata[CNT_W-1:0]),
            .ctl_wr_i   (ctl_wr[i]),
            .ctl_data_i (ctl_wdata),
            .restart_i  (rst_req[i]),
            .flag_clr_i (flag_clr[i]),
            .cnt_o      (cnt[i]),
            .load_o     (load[i]),
            .ctl_o      (ctl[i]),
            .flag_o     (flag[i])
         );
         assign en[i]   = ctl[i].en;
         assign mode[i] = ctl[i].mode;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (slot == '0 && regi == 4'h0)
         bus_rdata[N_TIMERS-1:0] = flag;
      for (int i = 0; i < N_TIMERS; i++) begin
         if (slot == SLOT_W'(i + 1)) begin
            unique case (regi)
               4'h0: bus_rdata[CNT_W-1:0] = load[i];
               4'h4: bus_rdata[CNT_W-1:0] = cnt[i];
               4'h8: bus_rdata[7:0] = {ctl[i].en, 1'b0, ctl[i].mode, ctl[i].psel};
               default: ;
            endcase
         end
      end
   end

   assign irq = flag;
endmodule

module twin_tick_timer_chk #(
   parameter int N_TIMERS = 2,
   parameter int CNT_W    = 16
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [N_TIMERS-1:0]            en,
   input logic [N_TIMERS-1:0][1:0]       mode,
   input logic [N_TIMERS-1:0][CNT_W-1:0] cnt,
   input logic [N_TIMERS-1:0][CNT_W-1:0] load,
   input logic [N_TIMERS-1:0]            ld_wr,
   input logic [N_TIMERS-1:0]            rst_req,
   input logic [N_TIMERS-1:0]            irq
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   generate
      for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
         // R4
         hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !ld_wr[i] && !rst_req[i]) |=> $stable(cnt[i]));
         // R7
         oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && mode[i][1] && cnt[i] == '0 && !rst_req[i]) |=> (cnt[i] == '0));
         // R5
         free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && mode[i] == 2'd0 && cnt[i] == '0 && !rst_req[i])
            |=> (cnt[i] == '0 || cnt[i] == '1));
         // R6
         periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && mode[i] == 2'd1 && cnt[i] == '0 && !rst_req[i])
            |=> (cnt[i] == '0 || cnt[i] == $past(load[i])));
         // R10
         restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_req[i] |=> (cnt[i] == $past(load[i])));
         // R8
         irq_after_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> ($past(cnt[i]) == ONE && $past(en[i])));
      end
   endgenerate
endmodule

bind twin_tick_timer twin_tick_timer_chk #(.N_TIMERS(N_TIMERS), .CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .mode    (mode),
   .cnt     (cnt),
   .load    (load),
   .ld_wr   (ld_wr),
   .rst_req (rst_req),
   .irq     (irq)
);

// File: tb/twin_tick_timer_tb.sv
module twin_tick_timer_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  irq;
   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   twin_tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [7:0] a_ld(int t);  return 8'(16 * (t + 1));     endfunction
   function automatic logic [7:0] a_val(int t); return 8'(16 * (t + 1) + 4); endfunction
   function automatic logic [7:0] a_ctl(int t); return 8'(16 * (t + 1) + 8); endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // R3: step count equals floor(n / 2^(code+1)), code 0 steps every clock
   task automatic prescale_case(int t, int code, int n);
      logic [31:0] v;
      int d;
      d = (code == 0) ? 1 : (1 << (code + 1));
      wr(a_ctl(t), 0);
      wr(a_ld(t), 32'h8000);
      wr(a_ctl(t), 32'h80 | code);
      idle(n);
      rd(a_val(t), v);
      check($sformatf("R3 t%0d code%0d n%0d", t, code, n), v, 32'h8000 - n / d);
      wr(a_ctl(t), 0);
   endtask

   initial begin
      #(CLK_P * 190000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, keep1;
      idle(2);
      // R1 reset state
      for (int t = 0; t < 2; t++) begin
         rd(a_ld(t), v);  check("R1 load", v, 0);
         rd(a_val(t), v); check("R1 value", v, 0);
         rd(a_ctl(t), v); check("R1 ctrl", v, 0);
      end
      rd(8'h00, v); check("R1 status", v, 0);
      check("R1 irq", 32'(irq), 0);
      @(negedge clk); rst_n = 1'b1;

      // R2 readback and field masking
      for (int t = 0; t < 2; t++) begin
         wr(a_ld(t), 32'hABCD_1234 + t);
         rd(a_ld(t), v); check("R2 load readback", v, 32'h1234 + t);
         wr(a_ctl(t), 32'hFFFF_FF4F - 32'(t));
         wr(a_ctl(t), 32'hFFFF_FF7F & ~32'h80);
         rd(a_ctl(t), v); check("R2 ctrl readback", v, 32'h3F);
         wr(a_ctl(t), 0);
      end

      // R3 prescale sweep over both timers
      for (int t = 0; t < 2; t++)
         for (int c = 0; c <= 4; c++) begin
            int d;
            d = (c == 0) ? 1 : (1 << (c + 1));
            prescale_case(t, c, d - 1);
            prescale_case(t, c, 3 * d + 1);
         end
      prescale_case(0, 15, 65535);
      prescale_case(0, 15, 65536);

      for (int t = 0; t < 2; t++) begin
         // R5 free-running wrap, R8 flag and irq
         wr(a_ctl(t), 0);
         wr(8'h00, 32'h3);
         wr(a_ld(t), 2);
         wr(a_ctl(t), 32'h80);
         idle(2);
         rd(a_val(t), v); check("R5 reach zero", v, 0);
         check("R8 irq set", 32'(irq[t]), 1);
         rd(8'h00, v); check("R8 status flag", v & 32'(1 << t), 32'(1 << t));
         idle(1);
         rd(a_val(t), v); check("R5 wrap", v, 32'hFFFF);
         // R9 write 0 keeps, write 1 clears
         wr(8'h00, 0);
         check("R9 write zero keeps", 32'(irq[t]), 1);
         wr(8'h00, 32'(1 << t));
         check("R9 clear", 32'(irq[t]), 0);

         // R6 periodic reload
         wr(a_ctl(t), 0);
         wr(a_ld(t), 3);
         wr(a_ctl(t), 32'h90);
         idle(3);
         rd(a_val(t), v); check("R6 zero", v, 0);
         idle(1);
         rd(a_val(t), v); check("R6 reload", v, 3);
         wr(8'h00, 32'(1 << t));

         // R7 both one-shot modes park at zero
         for (int m = 2; m <= 3; m++) begin
            wr(a_ctl(t), 0);
            wr(a_ld(t), 2);
            wr(a_ctl(t), 32'h80 | (m << 4));
            idle(2);
            check("R8 one-shot flag", 32'(irq[t]), 1);
            wr(8'h00, 32'(1 << t));
            idle(10);
            rd(a_val(t), v); check("R7 parked", v, 0);
            check("R7 no new flag", 32'(irq[t]), 0);
         end

         // R11 load write while enabled leaves counter, disabled copies
         wr(a_ld(t), 77);
         rd(a_val(t), v); check("R11 enabled no copy", v, 0);
         rd(a_ld(t), v); check("R11 load stored", v, 77);
         wr(a_ctl(t), 0);
         wr(a_ld(t), 33);
         rd(a_val(t), v); check("R11 disabled copy", v, 33);
         // R4 disabled hold
         idle(10);
         rd(a_val(t), v); check("R4 hold", v, 33);

         // R10 restart with code 1 (divide by 4)
         wr(a_ld(t), 100);
         wr(a_ctl(t), 32'h91);
         idle(9);
         rd(a_val(t), v); check("R10 before restart", v, 98);
         if (t == 0) begin
            rd(a_val(1), keep1);
         end
         wr(8'h00, 32'(1 << (4 + t)));
         rd(a_val(t), v); check("R10 reloaded", v, 100);
         rd(8'h00, v); check("R10 bit reads zero", v & 32'h30, 0);
         idle(3);
         rd(a_val(t), v); check("R10 prescaler cleared", v, 100);
         idle(1);
         rd(a_val(t), v); check("R10 first step", v, 99);
         if (t == 0) begin
            rd(a_val(1), v); check("R12 other timer count", v, keep1);
            check("R12 other timer flag", 32'(irq[1]), 0);
         end
         wr(a_ctl(t), 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule